// File: doc/BRIEF.md
# Resumable NMI State Register Bank

This block keeps the machine-mode state that lets a hart return from a non-maskable interrupt. It holds four registers: a free scratch word, the saved program counter, the interrupt cause and a status word. The status word carries the previous privilege, the previous virtualization flag and the global NMI enable. Software reaches the registers through a plain CSR access port. Reads are combinational in the same cycle. Writes take effect at the next clock edge. Each field applies its own legal-value rules on writes and its own masking on reads.

A second port is driven by the trap sequencer. A trap-entry pulse loads the interrupted PC, cause code, privilege and virtualization flag, and it clears the enable. A trap-return pulse sets the enable again. The values the return logic needs (PC, privilege, virtualization) come out on dedicated output pins. The return PC has the same alignment masking as a CSR read. All ports are plain control pins: every access completes in one cycle, so there is no back-pressure to manage.

Top module: `rnmi_state_bank`

## Requirements
- R1: The scratch register at address 0x740 reads back exactly the last XLEN-bit value written to it.
- R2: Bit 0 of the saved PC (address 0x741) always reads as 0, on the CSR port and on `ret_pc`.
- R3: While `align32` is 1, bit 1 of the saved PC reads as 0 on the CSR port and on `ret_pc`. The stored bit 1 stays writable, and it reads back once `align32` returns to 0.
- R4: The cause register (address 0x742) always reads with bit XLEN-1 set. The low CODE_W bits hold the code, and every bit in between reads 0.
- R5: The status register (address 0x744) places the enable at bit 3, the previous-virtualization flag at bit 7 and the previous privilege at bits 12:11. Every other bit reads 0 whatever is written.
- R6: After reset, the enable, the privilege, the virtualization flag, the scratch register, the saved PC and the cause code are all 0.
- R7: A software status write with bit 3 set sets the enable. A write with bit 3 clear leaves the enable unchanged.
- R8: A software write of the reserved privilege encoding 2'b10 leaves the privilege field unchanged. The legal encodings are 00 user, 01 supervisor and 11 machine.
- R9: A `trap_entry` pulse stores `entry_pc` with bit 0 dropped, stores `entry_code`, `entry_priv` and `entry_virt`, and clears the enable.
- R10: When `trap_entry` and a software write to the saved PC, cause or status land in the same cycle, the trap-entry values win. A same-cycle write to the scratch register still takes effect.
- R11: A `trap_return` pulse without `trap_entry` sets the enable and leaves the other status fields unchanged.
- R12: An access with `csr_en` set to an unmapped address raises `csr_illegal` in the same cycle and reads 0. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_en | input | 1 | CSR access this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data (combinational) |
| csr_illegal | output | 1 | Access targets an unmapped address |
| align32 | input | 1 | 1 = 32-bit instruction alignment, 0 = 16-bit |
| trap_entry | input | 1 | Hardware capture at NMI entry |
| entry_pc | input | XLEN | Interrupted PC |
| entry_code | input | CODE_W | Interrupt cause code |
| entry_priv | input | 2 | Interrupted privilege |
| entry_virt | input | 1 | Interrupted virtualization flag |
| trap_return | input | 1 | Hardware return pulse, sets the enable |
| nmi_enable | output | 1 | NMI enable state |
| ret_pc | output | XLEN | PC to resume at (masked) |
| ret_priv | output | 2 | Privilege to resume in |
| ret_virt | output | 1 | Virtualization flag to resume with |

## Verification
The hardest case to reach is a collision between a trap-entry pulse and a software write in the same cycle. The stimulus raises `trap_entry` in the very cycle a status write with bit 3 set is issued, and again while saved-PC and scratch writes are in flight. The bench then reads back to confirm that only the scratch write survived. The hidden PC bit 1 is also hard to see: the bench writes it under 32-bit alignment, confirms that it reads as 0, and then drops to 16-bit alignment to make it reappear.

// File: rtl/rnmi_bank_pkg.sv
package rnmi_bank_pkg;

  localparam int ADDR_W    = 12;
  localparam int ENA_BIT   = 3;
  localparam int PVIRT_BIT = 7;
  localparam int PPRIV_LO  = 11;
  localparam int PPRIV_HI  = PPRIV_LO + 1;

  localparam logic [ADDR_W-1:0] A_SCRATCH = 12'h740;
  localparam logic [ADDR_W-1:0] A_EPC     = 12'h741;
  localparam logic [ADDR_W-1:0] A_CAUSE   = 12'h742;
  localparam logic [ADDR_W-1:0] A_STATUS  = 12'h744;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } priv_e;

  typedef struct packed {
    logic scratch;
    logic epc;
    logic cause;
    logic status;
  } reg_sel_t;

  function automatic logic priv_legal(input logic [1:0] p);
    return p != PRIV_RSVD;
  endfunction

endpackage

// File: rtl/rnmi_addr_decode.sv
module rnmi_addr_decode
  import rnmi_bank_pkg::*;
(
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output logic              illegal
);

  always_comb begin
    sel = '0;
    unique case (addr)
      A_SCRATCH: sel.scratch = 1'b1;
      A_EPC:     sel.epc     = 1'b1;
      A_CAUSE:   sel.cause   = 1'b1;
      A_STATUS:  sel.status  = 1'b1;
      default:   sel         = '0;
    endcase
    illegal = en && (sel == '0);
  end

endmodule

// File: rtl/rnmi_epc_reg.sv
module rnmi_epc_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we,
  input  logic [XLEN-1:0] sw_wdata,
  input  logic            hw_we,
  input  logic [XLEN-1:0] hw_pc,
  input  logic            align32,
  output logic [XLEN-1:0] view
);

  localparam int STORE_W = XLEN - 1;

  logic [STORE_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (hw_we)  pc_q <= hw_pc[XLEN-1:1];
    else if (sw_we)  pc_q <= sw_wdata[XLEN-1:1];
  end

  // bit 1 hidden (not cleared) under 32-bit alignment
  always_comb begin
    view = {pc_q, 1'b0};
    if (align32) view[1] = 1'b0;
  end

endmodule

// File: rtl/rnmi_cause_reg.sv
module rnmi_cause_reg #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [XLEN-1:0]   sw_wdata,
  input  logic              hw_we,
  input  logic [CODE_W-1:0] hw_code,
  output logic [XLEN-1:0]   view
);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= '0;
    else if (hw_we) code_q <= hw_code;
    else if (sw_we) code_q <= sw_wdata[CODE_W-1:0];
  end

  always_comb begin
    view             = '0;
    view[CODE_W-1:0] = code_q;
    view[XLEN-1]     = 1'b1;
  end

endmodule

// File: rtl/rnmi_status_reg.sv
module rnmi_status_reg
  import rnmi_bank_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we,
  input  logic [XLEN-1:0] sw_wdata,
  input  logic            hw_entry,
  input  logic [1:0]      hw_priv,
  input  logic            hw_virt,
  input  logic            hw_return,
  output logic            ena,
  output logic [1:0]      ppriv,
  output logic            pvirt,
  output logic [XLEN-1:0] view
);

  logic [1:0] wr_priv;
  assign wr_priv = sw_wdata[PPRIV_HI:PPRIV_LO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena   <= 1'b0;
      ppriv <= PRIV_USER;
      pvirt <= 1'b0;
    end else if (hw_entry) begin
      ena   <= 1'b0;
      ppriv <= hw_priv;
      pvirt <= hw_virt;
    end else begin
      if (hw_return) ena <= 1'b1;
      if (sw_we) begin
        if (sw_wdata[ENA_BIT]) ena <= 1'b1;
        if (priv_legal(wr_priv)) ppriv <= wr_priv;
        pvirt <= sw_wdata[PVIRT_BIT];
      end
    end
  end

  always_comb begin
    view                    = '0;
    view[ENA_BIT]           = ena;
    view[PVIRT_BIT]         = pvirt;
    view[PPRIV_HI:PPRIV_LO] = ppriv;
  end

endmodule

// File: rtl/rnmi_state_bank.sv
module rnmi_state_bank
  import rnmi_bank_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  input  logic              align32,
  input  logic              trap_entry,
  input  logic [XLEN-1:0]   entry_pc,
  input  logic [CODE_W-1:0] entry_code,
  input  logic [1:0]        entry_priv,
  input  logic              entry_virt,
  input  logic              trap_return,
  output logic              nmi_enable,
  output logic [XLEN-1:0]   ret_pc,
  output logic [1:0]        ret_priv,
  output logic              ret_virt
);

  reg_sel_t        sel;
  logic            wr_ok;
  logic [XLEN-1:0] scratch_q;
  logic [XLEN-1:0] epc_view;
  logic [XLEN-1:0] cause_view;
  logic [XLEN-1:0] status_view;

  rnmi_addr_decode u_dec (
    .en      (csr_en),
    .addr    (csr_addr),
    .sel     (sel),
    .illegal (csr_illegal)
  );

  assign wr_ok = csr_en && csr_we && !csr_illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  scratch_q <= '0;
    else if (wr_ok && sel.scratch) scratch_q <= csr_wdata;
  end

  rnmi_epc_reg #(.XLEN(XLEN)) u_epc (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (wr_ok && sel.epc),
    .sw_wdata (csr_wdata),
    .hw_we    (trap_entry),
    .hw_pc    (entry_pc),
    .align32  (align32),
    .view     (epc_view)
  );

  rnmi_cause_reg #(.XLEN(XLEN), .CODE_W(CODE_W)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (wr_ok && sel.cause),
    .sw_wdata (csr_wdata),
    .hw_we    (trap_entry),
    .hw_code  (entry_code),
    .view     (cause_view)
  );

  rnmi_status_reg #(.XLEN(XLEN)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (wr_ok && sel.status),
    .sw_wdata  (csr_wdata),
    .hw_entry  (trap_entry),
    .hw_priv   (entry_priv),
    .hw_virt   (entry_virt),
    .hw_return (trap_return),
    .ena       (nmi_enable),
    .ppriv     (ret_priv),
    .pvirt     (ret_virt),
    .view      (status_view)
  );

  assign ret_pc = epc_view;

  always_comb begin
    csr_rdata = '0;
    unique case (1'b1)
      sel.scratch: csr_rdata = scratch_q;
      sel.epc:     csr_rdata = epc_view;
      sel.cause:   csr_rdata = cause_view;
      sel.status:  csr_rdata = status_view;
      default:     csr_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rnmi_state_bank_chk.sv
module rnmi_state_bank_chk
  import rnmi_bank_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_en,
  input logic [11:0]     csr_addr,
  input logic [XLEN-1:0] csr_rdata,
  input logic            csr_illegal,
  input logic            align32,
  input logic            trap_entry,
  input logic            trap_return,
  input logic            nmi_enable,
  input logic [XLEN-1:0] ret_pc
);

  localparam logic [XLEN-1:0] STATUS_MASK =
    (XLEN'(1) << ENA_BIT) | (XLEN'(1) << PVIRT_BIT) | (XLEN'(3) << PPRIV_LO);

  logic mapped;
  assign mapped = (csr_addr == A_SCRATCH) || (csr_addr == A_EPC) ||
                  (csr_addr == A_CAUSE)   || (csr_addr == A_STATUS);

  assert_pc_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pc[0] == 1'b0);

  assert_pc_bit1_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    align32 |-> (ret_pc[1] == 1'b0));

  assert_cause_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == A_CAUSE) |-> csr_rdata[XLEN-1]);

  assert_status_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == A_STATUS) |-> ((csr_rdata & ~STATUS_MASK) == '0));

  assert_reset_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !nmi_enable);

  assert_enable_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_enable && !trap_entry) |=> nmi_enable);

  assert_entry_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_entry |=> !nmi_enable);

  assert_return_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_return && !trap_entry) |=> nmi_enable);

  assert_unmapped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && !mapped) |-> (csr_illegal && csr_rdata == '0));

endmodule

bind rnmi_state_bank rnmi_state_bank_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_en      (csr_en),
  .csr_addr    (csr_addr),
  .csr_rdata   (csr_rdata),
  .csr_illegal (csr_illegal),
  .align32     (align32),
  .trap_entry  (trap_entry),
  .trap_return (trap_return),
  .nmi_enable  (nmi_enable),
  .ret_pc      (ret_pc)
);

// File: tb/rnmi_state_bank_bench.sv
`timescale 1ns/1ps
module rnmi_state_bank_bench;

  localparam int XLEN   = 32;
  localparam int CODE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              csr_en = 1'b0, csr_we = 1'b0;
  logic [11:0]       csr_addr = '0;
  logic [XLEN-1:0]   csr_wdata = '0;
  logic [XLEN-1:0]   csr_rdata;
  logic              csr_illegal;
  logic              align32 = 1'b0;
  logic              trap_entry = 1'b0, trap_return = 1'b0;
  logic [XLEN-1:0]   entry_pc = '0;
  logic [CODE_W-1:0] entry_code = '0;
  logic [1:0]        entry_priv = '0;
  logic              entry_virt = 1'b0;
  logic              nmi_enable;
  logic [XLEN-1:0]   ret_pc;
  logic [1:0]        ret_priv;
  logic              ret_virt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [XLEN-1:0] data;
    logic            ill;
    string           tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  rnmi_state_bank #(.XLEN(XLEN), .CODE_W(CODE_W)) u_rnmi_state_bank (
    .clk, .rst_n, .csr_en, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
    .csr_illegal, .align32, .trap_entry, .entry_pc, .entry_code,
    .entry_priv, .entry_virt, .trap_return, .nmi_enable, .ret_pc,
    .ret_priv, .ret_virt
  );

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read access
  always @(negedge clk) begin
    if (rst_n && csr_en && !csr_we) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard-empty", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " rdata"}, csr_rdata, e.data);
        chk({e.tag, " illegal"}, {31'd0, csr_illegal}, {31'd0, e.ill});
      end
    end
  end

  task automatic rd(logic [11:0] a, logic [XLEN-1:0] exp, logic ill, string tag);
    exp_t e;
    e.data = exp; e.ill = ill; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    csr_en = 1; csr_we = 0; csr_addr = a;
    @(posedge clk); #1;
    csr_en = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [XLEN-1:0] d);
    @(posedge clk); #1;
    csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1;
    csr_en = 0; csr_we = 0;
  endtask

  initial begin
    #150000;
    chk("watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R6 reset state
    @(negedge clk);
    chk("R6 enable", {31'd0, nmi_enable}, 0);
    rd(12'h744, 32'h0, 0, "R6 status");
    rd(12'h741, 32'h0, 0, "R6 pc");
    rd(12'h740, 32'h0, 0, "R6 scratch");
    rd(12'h742, 32'h8000_0000, 0, "R6 R4 cause");

    // R1 scratch
    wr(12'h740, 32'hDEAD_BEEF);
    rd(12'h740, 32'hDEAD_BEEF, 0, "R1 scratch a");
    wr(12'h740, 32'h1234_5678);
    rd(12'h740, 32'h1234_5678, 0, "R1 scratch b");

    // R2 / R3 saved PC
    wr(12'h741, 32'hFFFF_FFFF);
    rd(12'h741, 32'hFFFF_FFFE, 0, "R2 pc bit0");
    align32 = 1;
    rd(12'h741, 32'hFFFF_FFFC, 0, "R3 pc masked");
    @(negedge clk);
    chk("R3 ret_pc masked", ret_pc, 32'hFFFF_FFFC);
    wr(12'h741, 32'h0000_1002);
    rd(12'h741, 32'h0000_1000, 0, "R3 pc write under align32");
    align32 = 0;
    rd(12'h741, 32'h0000_1002, 0, "R3 bit1 reappears");
    @(negedge clk);
    chk("R3 R2 ret_pc", ret_pc, 32'h0000_1002);

    // R4 cause
    wr(12'h742, 32'h0000_FFA5);
    rd(12'h742, 32'h8000_00A5, 0, "R4 cause code");

    // R5 / R7 status
    wr(12'h744, 32'hFFFF_FFF7);
    rd(12'h744, 32'h0000_1880, 0, "R5 R7 fields, enable not set");
    wr(12'h744, 32'h0000_0008);
    rd(12'h744, 32'h0000_0008, 0, "R7 enable set");
    wr(12'h744, 32'h0000_0000);
    rd(12'h744, 32'h0000_0008, 0, "R7 clear ignored");
    @(negedge clk);
    chk("R7 nmi_enable", {31'd0, nmi_enable}, 1);

    // R8 privilege legality
    wr(12'h744, 32'h0000_0808);
    rd(12'h744, 32'h0000_0808, 0, "R8 priv supervisor");
    wr(12'h744, 32'h0000_1008);
    rd(12'h744, 32'h0000_0808, 0, "R8 reserved priv ignored");

    // R9 / R10 trap entry colliding with software writes
    @(posedge clk); #1;
    trap_entry = 1; entry_pc = 32'h0000_2003; entry_code = 8'h1F;
    entry_priv = 2'b11; entry_virt = 1;
    csr_en = 1; csr_we = 1; csr_addr = 12'h744; csr_wdata = 32'h0000_0008;
    @(posedge clk); #1;
    trap_entry = 0; csr_en = 0; csr_we = 0;
    @(negedge clk);
    chk("R9 R10 enable cleared", {31'd0, nmi_enable}, 0);
    chk("R9 ret_pc", ret_pc, 32'h0000_2002);
    chk("R9 ret_priv", {30'd0, ret_priv}, 3);
    chk("R9 ret_virt", {31'd0, ret_virt}, 1);
    rd(12'h744, 32'h0000_1880, 0, "R9 R10 status");
    rd(12'h742, 32'h8000_001F, 0, "R9 cause");

    @(posedge clk); #1;
    trap_entry = 1; entry_pc = 32'h0000_4000; entry_code = 8'h02;
    entry_priv = 2'b00; entry_virt = 0;
    csr_en = 1; csr_we = 1; csr_addr = 12'h741; csr_wdata = 32'h0000_5555;
    @(posedge clk); #1;
    csr_addr = 12'h740; csr_wdata = 32'hA5A5_A5A5;
    entry_pc = 32'h0000_6000;
    @(posedge clk); #1;
    trap_entry = 0; csr_en = 0; csr_we = 0;
    rd(12'h741, 32'h0000_6000, 0, "R10 pc write lost");
    rd(12'h740, 32'hA5A5_A5A5, 0, "R10 scratch write kept");

    // R11 trap return
    @(posedge clk); #1 trap_return = 1;
    @(posedge clk); #1 trap_return = 0;
    @(negedge clk);
    chk("R11 enable set", {31'd0, nmi_enable}, 1);
    rd(12'h744, 32'h0000_0008, 0, "R11 status fields kept");

    // R12 unmapped
    rd(12'h743, 32'h0, 1, "R12 unmapped read");
    @(posedge clk); #1;
    csr_en = 1; csr_we = 1; csr_addr = 12'h743; csr_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R12 illegal on write", {31'd0, csr_illegal}, 1);
    @(posedge clk); #1;
    csr_en = 0; csr_we = 0;
    rd(12'h740, 32'hA5A5_A5A5, 0, "R12 scratch untouched");
    rd(12'h744, 32'h0000_0008, 0, "R12 status untouched");

    repeat (3) @(posedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1;
    $finish;
  end

endmodule